// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block produces the Start condition of an I2C master on behalf of a host. The host sets a start-enable bit through a small register-style write port. The block checks that both bus lines are idle-high and then times two equal phases with a reloadable 7-bit down-counter. At the end of the first phase it pulls SDA low while SCL stays released, which forms the Start condition. At the end of the second phase it clears the start-enable bit and leaves SDA held low, ready for the first data bit.

Both lines are driven as open-drain enables: asserting an enable pulls the line low, and releasing it lets the pull-up raise it. Before SDA is pulled, the block watches for another master. If a line is low when the request is examined, if SCL falls during the first phase, or if SDA is found low at the first timeout, the block sets a sticky bus-collision flag, releases the bus and returns to idle. While a start is pending, the block locks out control writes and data-buffer writes. A buffer write in that window sets a sticky write-collision flag instead of loading the buffer.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset, both line enables are released and every flag reads 0. The control field, the data buffer and the start-enable bit (control bit 0) also read 0.
- R2: Take the edge that writes a 1 to control bit 0 as edge 0, with both lines high, and let N be the reload value. At edge N+2 the block asserts the SDA enable. SCL is released at that moment.
- R3: The start-detected bit and the interrupt flag (flag-clear bit 0) are set on the same edge on which the SDA enable is asserted.
- R4: A second phase of N+1 cycles follows. Control bit 0 then reads 0 from edge 2N+3 onward, and the SDA enable stays asserted.
- R5: The request is examined on the edge after it is written. If either line is low then, the bus-collision flag (flag-clear bit 1) is set on that edge. On that same edge control bit 0 is cleared, the SDA enable stays released and start-detected stays 0.
- R6: In the first phase, SCL sampled low on any edge aborts the start on that edge. So does SDA sampled low at the first timeout. Either abort sets the bus-collision flag, clears control bit 0 and leaves SDA released.
- R7: While control bit 0 reads 1, a data-buffer write sets the write-collision flag (flag-clear bit 2) and leaves the buffer unchanged. At other times a buffer write loads the buffer and leaves the write-collision flag as it was.
- R8: While control bit 0 reads 1, a control write is ignored and the whole control field keeps its value. At other times a control write loads the field.
- R9: The interrupt, bus-collision and write-collision flags are sticky. A flag-clear write clears each flag whose bit is 1 and leaves the others unchanged, and a set event wins over a clear in the same cycle. A start may be requested while the bus-collision flag is set.
- R10: An accepted write of 1 to control bit 0 releases the SDA enable and clears start-detected on the write edge.
- R11: The SCL enable is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-field write strobe |
| ctrl_wdata | input | 5 | Control-field write data; bit 0 is start enable |
| buf_wr | input | 1 | Data-buffer write strobe |
| buf_wdata | input | 8 | Data-buffer write data |
| reload | input | 7 | Baud counter reload value N |
| flag_clr_wr | input | 1 | Flag-clear write strobe |
| flag_clr | input | 3 | Clear mask: bit 0 interrupt, bit 1 bus collision, bit 2 write collision |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | SDA pull-low enable |
| scl_oe | output | 1 | SCL pull-low enable |
| start_det | output | 1 | Start-detected status bit |
| intr_flag | output | 1 | Interrupt flag |
| bcol_flag | output | 1 | Bus-collision flag |
| wcol_flag | output | 1 | Write-collision flag |
| ctrl_rd | output | 5 | Control-field read-back |
| buf_q | output | 8 | Data-buffer contents |

## Verification
Count from the write edge of a start request. Control bit 0 reads 1 one cycle after the write. The SDA enable, start-detected and the interrupt flag appear N+2 cycles after that edge, and control bit 0 clears 2N+3 cycles after it. Collision flags, ignored writes and flag clears act on the very next edge. Each stimulus task works out these absolute cycle numbers from the reload value and places the expected values in a cycle-sorted queue. A monitor compares them on falling edges, so every check is taken in exactly the cycle the result is due, and an item left behind its cycle counts as a failure.

// File: rtl/i2c_start_pkg.sv
// Shared definitions for the start-condition sequencer.
// Assumes: flag index order matches the flag_clr mask documented at the top.
package i2c_start_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2
    } seq_state_e;

    localparam int FLG_INTR = 0;
    localparam int FLG_BCOL = 1;
    localparam int FLG_WCOL = 2;
    localparam int FLG_N    = 3;
endpackage

// File: rtl/i2c_baud_timer.sv
// Reloadable down-counter that times one sequencer phase.
// Assumes: load has priority over counting; tc is meaningful only while run=1,
// so one phase spans reload+1 cycles from the load edge to the acting edge.
module i2c_baud_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tc
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load, then decrement toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count flag for the controlling state machine.
    always_comb tc = run && (cnt_q == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
// Phase sequencer: checks the bus, runs two timed phases and drives SDA.
// Assumes: start_en is the registered control bit; start_acc pulses on the edge
// that sets it. Events are single-cycle combinational pulses to the registers.
module i2c_start_fsm
    import i2c_start_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_en,
    input  logic start_acc,
    input  logic sda_in,
    input  logic scl_in,
    input  logic tc,
    output logic ld,
    output logic run,
    output logic sda_oe,
    output logic ev_start,
    output logic ev_done,
    output logic ev_bcol
);
    seq_state_e state_q, state_d;

    // Next-state and event decode for the start sequence.
    always_comb begin
        state_d  = state_q;
        ld       = 1'b0;
        ev_start = 1'b0;
        ev_done  = 1'b0;
        ev_bcol  = 1'b0;
        run      = (state_q != ST_IDLE);
        case (state_q)
            ST_IDLE: begin
                if (start_en) begin
                    if (sda_in && scl_in) begin
                        ld      = 1'b1;
                        state_d = ST_PH1;
                    end else begin
                        ev_bcol = 1'b1;
                    end
                end
            end
            ST_PH1: begin
                if (!scl_in) begin
                    ev_bcol = 1'b1;
                    state_d = ST_IDLE;
                end else if (tc) begin
                    if (sda_in) begin
                        ev_start = 1'b1;
                        ld       = 1'b1;
                        state_d  = ST_PH2;
                    end else begin
                        ev_bcol = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PH2: begin
                if (tc) begin
                    ev_done = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // SDA pull-low enable: set at the Start, released by abort or new request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sda_oe <= 1'b0;
        else if (ev_bcol || start_acc) sda_oe <= 1'b0;
        else if (ev_start)           sda_oe <= 1'b1;
    end
endmodule

// File: rtl/i2c_start_regs.sv
// Host-visible registers: control field with lockout, data buffer, status
// bit and sticky flags. Assumes control bit 0 is the start enable and that a
// set event outranks a host clear.
module i2c_start_regs
    import i2c_start_pkg::*;
#(
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              flag_clr_wr,
    input  logic [FLG_N-1:0]  flag_clr,
    input  logic              ev_start,
    input  logic              ev_done,
    input  logic              ev_bcol,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] buf_q,
    output logic              start_det,
    output logic [FLG_N-1:0]  flag_q,
    output logic              start_acc
);
    logic             locked;
    logic             ctrl_take;
    logic [FLG_N-1:0] flag_set;

    // Write qualification against the in-progress lockout.
    always_comb begin
        locked    = ctrl_q[0];
        ctrl_take = ctrl_wr && !locked;
        start_acc = ctrl_take && ctrl_wdata[0];
    end

    // Control field: host load when unlocked, hardware clears start enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q    <= '0;
        else if (ctrl_take)          ctrl_q    <= ctrl_wdata;
        else if (ev_done || ev_bcol) ctrl_q[0] <= 1'b0;
    end

    // Data buffer: loads only while no start is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                 buf_q <= '0;
        else if (buf_wr && !locked) buf_q <= buf_wdata;
    end

    // Start-detected bit: set at the Start, cleared by a new request or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                     start_det <= 1'b0;
        else if (ev_start)              start_det <= 1'b1;
        else if (start_acc || ev_bcol)  start_det <= 1'b0;
    end

    // Set sources of the sticky flags.
    always_comb begin
        flag_set           = '0;
        flag_set[FLG_INTR] = ev_start;
        flag_set[FLG_BCOL] = ev_bcol;
        flag_set[FLG_WCOL] = buf_wr && locked;
    end

    generate
        for (genvar i = 0; i < FLG_N; i++) begin : g_flag
            // One sticky flag: set wins, then host clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                        flag_q[i] <= 1'b0;
                else if (flag_set[i])              flag_q[i] <= 1'b1;
                else if (flag_clr_wr && flag_clr[i]) flag_q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/i2c_start_seq.sv
// Top of the I2C master start-condition sequencer. Ties the host registers,
// the phase state machine and the baud timer together. Assumes sda_in and
// scl_in are already synchronised samples of the wired bus.
module i2c_start_seq
    import i2c_start_pkg::*;
#(
    parameter int BRG_W  = 7,
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic [BRG_W-1:0]  reload,
    input  logic              flag_clr_wr,
    input  logic [FLG_N-1:0]  flag_clr,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              start_det,
    output logic              intr_flag,
    output logic              bcol_flag,
    output logic              wcol_flag,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] buf_q
);
    logic             ld, run, tc;
    logic             ev_start, ev_done, ev_bcol, start_acc;
    logic [FLG_N-1:0] flag_q;

    i2c_start_regs #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr),
        .ev_start(ev_start), .ev_done(ev_done), .ev_bcol(ev_bcol),
        .ctrl_q(ctrl_rd), .buf_q(buf_q), .start_det(start_det),
        .flag_q(flag_q), .start_acc(start_acc)
    );

    i2c_start_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_en(ctrl_rd[0]), .start_acc(start_acc),
        .sda_in(sda_in), .scl_in(scl_in), .tc(tc),
        .ld(ld), .run(run), .sda_oe(sda_oe),
        .ev_start(ev_start), .ev_done(ev_done), .ev_bcol(ev_bcol)
    );

    i2c_baud_timer #(.CNT_W(BRG_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(ld), .run(run), .reload(reload), .tc(tc)
    );

    // Flag fan-out and the SCL enable, which the Start never pulls.
    always_comb begin
        intr_flag = flag_q[FLG_INTR];
        bcol_flag = flag_q[FLG_BCOL];
        wcol_flag = flag_q[FLG_WCOL];
        scl_oe    = 1'b0;
    end
endmodule

// File: rtl/i2c_start_chk.sv
// Assertion checker for i2c_start_seq, attached by bind below.
// Assumes default-width control (bit 0 start enable) and port-level access only.
module i2c_start_chk #(
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              req_bit,
    input logic              buf_wr,
    input logic              flag_clr_wr,
    input logic              clr_bcol,
    input logic              sda_in,
    input logic              scl_in,
    input logic              sda_oe,
    input logic              scl_oe,
    input logic              start_det,
    input logic              intr_flag,
    input logic              bcol_flag,
    input logic              wcol_flag,
    input logic [CTRL_W-1:0] ctrl_rd,
    input logic [DATA_W-1:0] buf_q
);
    // R11: SCL is never pulled.
    a_r11_scl_released: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_oe);

    // R2: SDA is pulled only after both lines were seen high.
    a_r2_sda_low_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_in && sda_in));

    // R3: status and interrupt accompany the Start.
    a_r3_flags_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (start_det && intr_flag));

    // R5, R6: a collision leaves the bus released and the request cleared.
    a_r5_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol_flag) |-> (!sda_oe && !ctrl_rd[0] && !start_det));

    // R7: a buffer write during a pending start is refused and flagged.
    a_r7_buf_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && buf_wr) |=> ($stable(buf_q) && wcol_flag));

    // R8: control writes are ignored while a start is pending.
    a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && ctrl_wr) |=> $stable(ctrl_rd[CTRL_W-1:1]));

    // R9: the bus-collision flag holds until cleared.
    a_r9_bcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bcol_flag && !(flag_clr_wr && clr_bcol)) |=> bcol_flag);

    // R10: an accepted request releases SDA and clears start-detected.
    a_r10_request_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_rd[0] && req_bit) |=> (!sda_oe && !start_det));
endmodule

bind i2c_start_seq i2c_start_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .req_bit(ctrl_wdata[0]),
    .buf_wr(buf_wr), .flag_clr_wr(flag_clr_wr), .clr_bcol(flag_clr[1]),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .start_det(start_det), .intr_flag(intr_flag), .bcol_flag(bcol_flag),
    .wcol_flag(wcol_flag), .ctrl_rd(ctrl_rd), .buf_q(buf_q)
);

// File: tb/tb_i2c_start_seq.sv
`timescale 1ns/1ps
module tb_i2c_start_seq;
    localparam int K_SDA = 0, K_SCL = 1, K_SDET = 2, K_INTR = 3, K_BCOL = 4;
    localparam int K_WCOL = 5, K_EN = 6, K_CTRL = 7, K_BUF = 8;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ctrl_wr = 1'b0, buf_wr = 1'b0, flag_clr_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [7:0] buf_wdata = '0;
    logic [6:0] reload = '0;
    logic [2:0] flag_clr = '0;
    logic       sda_ext = 1'b1, scl_ext = 1'b1;
    logic       sda_in, scl_in, sda_oe, scl_oe;
    logic       start_det, intr_flag, bcol_flag, wcol_flag;
    logic [4:0] ctrl_rd;
    logic [7:0] buf_q;

    int   cyc = 0, checks = 0, failures = 0;
    exp_t q[$];

    assign sda_in = sda_ext && !sda_oe;
    assign scl_in = scl_ext && !scl_oe;

    i2c_start_seq dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .reload(reload),
        .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .start_det(start_det), .intr_flag(intr_flag), .bcol_flag(bcol_flag),
        .wcol_flag(wcol_flag), .ctrl_rd(ctrl_rd), .buf_q(buf_q)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(input int kind);
        case (kind)
            K_SDA:   return int'(sda_oe);
            K_SCL:   return int'(scl_oe);
            K_SDET:  return int'(start_det);
            K_INTR:  return int'(intr_flag);
            K_BCOL:  return int'(bcol_flag);
            K_WCOL:  return int'(wcol_flag);
            K_EN:    return int'(ctrl_rd[0]);
            K_CTRL:  return int'(ctrl_rd);
            default: return int'(buf_q);
        endcase
    endfunction

    // Driver side: insert an expected value, kept sorted by due cycle.
    task automatic expect_at(input int c, input int kind, input int val, input string tag);
        exp_t it;
        int   pos;
        it.cyc = c; it.kind = kind; it.val = val; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > c) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    // Monitor: pop and compare every item due in the current cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t it;
                int   act;
                it = q.pop_front();
                checks++;
                act = observe(it.kind);
                if (it.cyc != cyc) begin
                    failures++;
                    $display("FAIL %s kind=%0d missed cycle %0d (now %0d) actual=%0d expected=%0d",
                             it.tag, it.kind, it.cyc, cyc, act, it.val);
                end else if (act != it.val) begin
                    failures++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                             it.tag, it.kind, cyc, act, it.val);
                end
            end
        end
    end

    // A full start with reload r; optional lockout poke at offset 3.
    task automatic run_start(input int r, input bit poke, input int old_buf);
        int c;
        @(negedge clk);
        c = cyc;
        reload = 7'(r);
        ctrl_wr = 1'b1; ctrl_wdata = 5'b00001;
        expect_at(c + 1, K_EN, 1, "R10");
        expect_at(c + 1, K_SDA, 0, "R10");
        expect_at(c + 1, K_SDET, 0, "R10");
        expect_at(c + r + 2, K_SDA, 0, "R2");
        expect_at(c + r + 3, K_SDA, 1, "R2");
        expect_at(c + r + 3, K_SCL, 0, "R11");
        expect_at(c + r + 3, K_SDET, 1, "R3");
        expect_at(c + r + 3, K_INTR, 1, "R3");
        expect_at(c + 2 * r + 3, K_EN, 1, "R4");
        expect_at(c + 2 * r + 4, K_EN, 0, "R4");
        expect_at(c + 2 * r + 4, K_SDA, 1, "R4");
        if (poke) begin
            expect_at(c + 4, K_CTRL, 1, "R8");
            expect_at(c + 4, K_BUF, old_buf, "R7");
            expect_at(c + 4, K_WCOL, 1, "R7");
        end
        @(negedge clk);
        ctrl_wr = 1'b0;
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            ctrl_wr = 1'b1; ctrl_wdata = 5'b11110;
            buf_wr = 1'b1; buf_wdata = 8'hC3;
            @(negedge clk);
            ctrl_wr = 1'b0; buf_wr = 1'b0;
        end
        while (cyc < c + 2 * r + 5) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [2:0] m, input int ei, input int eb,
                               input int ew);
        int c;
        @(negedge clk);
        c = cyc;
        flag_clr_wr = 1'b1; flag_clr = m;
        expect_at(c + 1, K_INTR, ei, "R9");
        expect_at(c + 1, K_BCOL, eb, "R9");
        expect_at(c + 1, K_WCOL, ew, "R9");
        @(negedge clk);
        flag_clr_wr = 1'b0; flag_clr = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        c = cyc;
        expect_at(c + 1, K_SDA, 0, "R1");
        expect_at(c + 1, K_SCL, 0, "R1");
        expect_at(c + 1, K_SDET, 0, "R1");
        expect_at(c + 1, K_INTR, 0, "R1");
        expect_at(c + 1, K_BCOL, 0, "R1");
        expect_at(c + 1, K_WCOL, 0, "R1");
        expect_at(c + 1, K_CTRL, 0, "R1");
        expect_at(c + 1, K_BUF, 0, "R1");
        repeat (2) @(negedge clk);

        run_start(3, 1'b0, 0);

        // R7, R8: idle writes load normally
        @(negedge clk);
        c = cyc;
        ctrl_wr = 1'b1; ctrl_wdata = 5'b10100;
        buf_wr = 1'b1; buf_wdata = 8'h5A;
        expect_at(c + 1, K_CTRL, 5'b10100, "R8");
        expect_at(c + 1, K_BUF, 8'h5A, "R7");
        expect_at(c + 1, K_WCOL, 0, "R7");
        @(negedge clk);
        ctrl_wr = 1'b0; buf_wr = 1'b0;

        clear_flags(3'b001, 0, 0, 0);
        run_start(0, 1'b0, 0);

        // R5: SDA held low by another master at request time
        @(negedge clk);
        sda_ext = 1'b0;
        c = cyc;
        ctrl_wr = 1'b1; ctrl_wdata = 5'b00001;
        expect_at(c + 1, K_EN, 1, "R5");
        expect_at(c + 2, K_BCOL, 1, "R5");
        expect_at(c + 2, K_EN, 0, "R5");
        expect_at(c + 2, K_SDA, 0, "R5");
        expect_at(c + 2, K_SDET, 0, "R5");
        @(negedge clk);
        ctrl_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sda_ext = 1'b1;

        // R9: start allowed with bus collision still set; R7/R8 lockout poke
        expect_at(cyc + 2, K_BCOL, 1, "R9");
        run_start(5, 1'b1, 8'h5A);
        clear_flags(3'b010, 1, 0, 1);
        clear_flags(3'b101, 0, 0, 0);

        // R6: SCL pulled low during the first phase
        @(negedge clk);
        c = cyc;
        reload = 7'd6;
        ctrl_wr = 1'b1; ctrl_wdata = 5'b00001;
        expect_at(c + 3, K_BCOL, 0, "R6");
        expect_at(c + 4, K_BCOL, 1, "R6");
        expect_at(c + 4, K_EN, 0, "R6");
        expect_at(c + 4, K_SDA, 0, "R6");
        @(negedge clk);
        ctrl_wr = 1'b0;
        while (cyc < c + 3) @(negedge clk);
        scl_ext = 1'b0;
        @(negedge clk);
        scl_ext = 1'b1;
        repeat (2) @(negedge clk);
        clear_flags(3'b010, 0, 0, 0);

        // R6: SDA found low at the first timeout
        @(negedge clk);
        c = cyc;
        reload = 7'd2;
        ctrl_wr = 1'b1; ctrl_wdata = 5'b00001;
        expect_at(c + 5, K_BCOL, 1, "R6");
        expect_at(c + 5, K_SDA, 0, "R6");
        expect_at(c + 5, K_SDET, 0, "R6");
        expect_at(c + 5, K_EN, 0, "R6");
        @(negedge clk);
        ctrl_wr = 1'b0;
        while (cyc < c + 4) @(negedge clk);
        sda_ext = 1'b0;
        @(negedge clk);
        sda_ext = 1'b1;
        repeat (2) @(negedge clk);

        // Recovery after aborts
        run_start(1, 1'b0, 0);

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard left %0d items, expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule